// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block steps a small 8-bit accumulator machine through its instructions. On the first tick of every instruction it captures a 16-bit word from program memory. It splits the command byte into a group, an operation and an alternate-form flag. Then, on a fixed schedule for each instruction class, it raises strobes for the data memory and register file, for the two operand caches, for the ALU and the condition unit, and for the program counter. The ALU, the comparator and the memories live outside the block. They answer the strobes: the ALU gives a combinational result, the comparator gives a same-cycle skip decision, and the memory returns read data one cycle after a read strobe.

The program counter counts instruction words and is held inside the block. It advances on the last tick of every instruction. A skip instruction moves it past two further instructions. A jump loads it from the argument byte or from a memory location.

Top module: `instr_sequencer`

## Requirements
- R1: An instruction word carries the argument in bits 15:8 and the command in bits 7:0. In the command, bit 7 is the alternate flag, bits 6:3 are the group (0 idle, 1 load, 2 ALU, 3 move, 4 skip, 5 jump) and bits 2:0 are the operation. `opSel` shows bits 2:0 and `unsignedCmp` shows bit 7 of the captured command.
- R2: While reset is low, `pc` and `step` read 0.
- R3: `fetch` is high exactly when `step` is 0. `step` rises by one each tick and returns to 0 after the last tick. A single program-counter strobe, one of `pcIncr`, `pcSkip` or `pcJump`, marks that last tick and no other tick.
- R4: Load from memory (0x08 targets cache 0, 0x09 targets cache 1) takes 4 ticks. It reads address = argument at step 2 and loads the read data into the cache at step 3. Immediate load (0x88/0x89) takes 3 ticks and loads the argument at step 2. `cacheLoad` bit 0 selects cache 0 and bit 1 selects cache 1.
- R5: ALU-to-memory commands (0x10 to 0x17) take 4 ticks. The ALU result present at step 2 is written at step 3 to address = argument.
- R6: ALU-to-cache commands (0x90 to 0x97) take 3 ticks. They load the ALU result into cache 0 at step 2.
- R7: Register move (0x18) takes 7 ticks. It reads address = argument bits 7:4 at step 2 and writes that data at step 5 to address = argument bits 3:0.
- R8: Immediate move (0x98 to 0x9F) takes 6 ticks. It writes the argument at step 4 to address = command bits 2:0.
- R9: Skip commands (0x20 to 0x27, 0xA0 to 0xA7) raise `cmpEval` at step 1. When no skip happens they take 2 ticks and advance `pc` by 1. When a skip happens they take 3 ticks and advance `pc` by 3. Operation 0 never skips and operation 7 always skips, whatever `skipTaken` says.
- R10: Jump (0x28) reads address = argument at step 2 and loads `pc` from the read data at step 3. Immediate jump (0xA8) loads `pc` from the argument. Both take 4 ticks.
- R11: The following take 2 ticks, advance `pc` by 1 and raise no memory or cache strobe: command 0x00, group 0 with any operation or flag, groups 6 to 15, load operations 2 to 7, move operations 1 to 7 without the flag, and jump operations other than 0.
- R12: Outside jumps and skips, `pc` advances by one on the last tick and wraps from 255 to 0. `pc` holds on all other ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrWord | input | 16 | Program memory word at `pc` |
| memRdData | input | 8 | Memory read data, valid the tick after `memRdEn` |
| aluResult | input | 8 | Combinational ALU result for `opSel` |
| skipTaken | input | 1 | Condition unit decision during `cmpEval` |
| pc | output | 8 | Program counter (instruction index) |
| step | output | 3 | Tick number within the current instruction |
| fetch | output | 1 | Instruction word captured this tick |
| memAddr | output | 8 | Memory / register address |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Memory write data |
| cacheLoad | output | 2 | Per-cache load strobe |
| cacheData | output | 8 | Value loaded into the selected cache |
| opSel | output | 3 | Operation field for the ALU and condition unit |
| unsignedCmp | output | 1 | Alternate flag: unsigned comparison for skips |
| cmpEval | output | 1 | Condition unit evaluation strobe |
| pcIncr | output | 1 | Last tick, advance by one |
| pcSkip | output | 1 | Last tick, skip two instructions |
| pcJump | output | 1 | Last tick, load jump target |

## Verification
A corrupted step counter shows up within the same instruction. The tick count changes, or a memory, cache or comparator strobe appears at a step other than the scheduled one. A wrongly captured or wrongly decoded command shows on the first strobe that uses it, at the latest by step 2: a wrong address, wrong data, the wrong cache bit or the wrong class length. An error in the program counter shows when the instruction retires, as an end value other than one, three or the jump target past the start value. It then carries on into every later fetch.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // command byte layout is fixed by the instruction set
  localparam int CMD_W     = 8;
  localparam int ALT_BIT   = 7;
  localparam int MAX_TICKS = 7;
  localparam int STEP_W    = $clog2(MAX_TICKS);

  localparam logic [3:0] GRP_LOAD = 4'd1;
  localparam logic [3:0] GRP_ALU  = 4'd2;
  localparam logic [3:0] GRP_MOVE = 4'd3;
  localparam logic [3:0] GRP_SKIP = 4'd4;
  localparam logic [3:0] GRP_JUMP = 4'd5;

  localparam logic [STEP_W-1:0] ST_0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] ST_1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] ST_2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] ST_3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] ST_4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] ST_5 = STEP_W'(5);
  localparam logic [STEP_W-1:0] ST_6 = STEP_W'(6);

  typedef enum logic [3:0] {
    C_NOP, C_LOAD, C_ILOAD, C_ALUM, C_ALUC, C_MOV, C_IMOV, C_SKIP, C_JMP, C_IJMP
  } iclass_t;

  typedef enum logic [1:0] { SRC_MEM, SRC_ALU, SRC_ARG } dataSrc_t;
  typedef enum logic [1:0] { ADDR_ARG, ADDR_HI, ADDR_LO, ADDR_OPF } addrSel_t;
  typedef enum logic [1:0] { PC_HOLD, PC_INCR, PC_SKIP, PC_JUMP } pcAct_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     irLoad;
    logic     opLatch;
    dataSrc_t opSrc;
    addrSel_t addrSel;
    logic     memRd;
    logic     memWr;
    logic     cacheLd;
    logic     cacheSel;
    dataSrc_t cacheSrc;
    logic     cmpEval;
    pcAct_t   pcAct;
    logic     jumpFromMem;
  } seqCtl_t;

  function automatic iclass_t classify(input logic [CMD_W-1:0] cmd);
    iclass_t    c;
    logic       alt;
    logic [3:0] grp;
    logic [2:0] op;
    alt = cmd[ALT_BIT];
    grp = cmd[6:3];
    op  = cmd[2:0];
    c   = C_NOP;
    case (grp)
      GRP_LOAD: if (op[2:1] == 2'b00) c = alt ? C_ILOAD : C_LOAD;
      GRP_ALU:  c = alt ? C_ALUC : C_ALUM;
      GRP_MOVE: begin
        if (alt) c = C_IMOV;
        else if (op == 3'd0) c = C_MOV;
      end
      GRP_SKIP: c = C_SKIP;
      GRP_JUMP: if (op == 3'd0) c = alt ? C_IJMP : C_JMP;
      default:  c = C_NOP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  cmdByte,
  input  logic              skipTaken,
  output logic [STEP_W-1:0] step,
  output seqCtl_t           ctl
);

  iclass_t          cls;
  logic [2:0]       op;
  logic             skipNow;
  logic [STEP_W-1:0] stepQ;

  assign cls  = classify(cmdByte);
  assign op   = cmdByte[2:0];
  assign step = stepQ;

  // operation 0 never skips, operation 7 always skips
  always_comb begin
    if (op == 3'd0)      skipNow = 1'b0;
    else if (op == 3'd7) skipNow = 1'b1;
    else                 skipNow = skipTaken;
  end

  always_comb begin
    ctl = '0;
    if (stepQ == ST_0) begin
      ctl.irLoad = 1'b1;
    end else begin
      case (cls)
        C_LOAD: begin
          if (stepQ == ST_2) begin
            ctl.memRd   = 1'b1;
            ctl.addrSel = ADDR_ARG;
          end
          if (stepQ == ST_3) begin
            ctl.cacheLd  = 1'b1;
            ctl.cacheSel = op[0];
            ctl.cacheSrc = SRC_MEM;
            ctl.pcAct    = PC_INCR;
          end
        end
        C_ILOAD: begin
          if (stepQ == ST_2) begin
            ctl.cacheLd  = 1'b1;
            ctl.cacheSel = op[0];
            ctl.cacheSrc = SRC_ARG;
            ctl.pcAct    = PC_INCR;
          end
        end
        C_ALUM: begin
          if (stepQ == ST_2) begin
            ctl.opLatch = 1'b1;
            ctl.opSrc   = SRC_ALU;
          end
          if (stepQ == ST_3) begin
            ctl.memWr   = 1'b1;
            ctl.addrSel = ADDR_ARG;
            ctl.pcAct   = PC_INCR;
          end
        end
        C_ALUC: begin
          if (stepQ == ST_2) begin
            ctl.cacheLd  = 1'b1;
            ctl.cacheSel = 1'b0;
            ctl.cacheSrc = SRC_ALU;
            ctl.pcAct    = PC_INCR;
          end
        end
        C_MOV: begin
          if (stepQ == ST_2) begin
            ctl.memRd   = 1'b1;
            ctl.addrSel = ADDR_HI;
          end
          if (stepQ == ST_3) begin
            ctl.opLatch = 1'b1;
            ctl.opSrc   = SRC_MEM;
          end
          if (stepQ == ST_5) begin
            ctl.memWr   = 1'b1;
            ctl.addrSel = ADDR_LO;
          end
          if (stepQ == ST_6) ctl.pcAct = PC_INCR;
        end
        C_IMOV: begin
          if (stepQ == ST_2) begin
            ctl.opLatch = 1'b1;
            ctl.opSrc   = SRC_ARG;
          end
          if (stepQ == ST_4) begin
            ctl.memWr   = 1'b1;
            ctl.addrSel = ADDR_OPF;
          end
          if (stepQ == ST_5) ctl.pcAct = PC_INCR;
        end
        C_SKIP: begin
          if (stepQ == ST_1) begin
            ctl.cmpEval = 1'b1;
            ctl.pcAct   = skipNow ? PC_HOLD : PC_INCR;
          end
          if (stepQ == ST_2) ctl.pcAct = PC_SKIP;
        end
        C_JMP: begin
          if (stepQ == ST_2) begin
            ctl.memRd   = 1'b1;
            ctl.addrSel = ADDR_ARG;
          end
          if (stepQ == ST_3) begin
            ctl.pcAct       = PC_JUMP;
            ctl.jumpFromMem = 1'b1;
          end
        end
        C_IJMP: begin
          if (stepQ == ST_3) ctl.pcAct = PC_JUMP;
        end
        default: begin
          ctl.pcAct = PC_INCR;
        end
      endcase
    end
  end

  // the tick that updates the program counter is the last one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    stepQ <= ST_0;
    else if (ctl.pcAct != PC_HOLD) stepQ <= ST_0;
    else                          stepQ <= stepQ + ST_1;
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PC_W       = 8,
  parameter int SKIP_COUNT = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W+CMD_W-1:0] instrWord,
  input  logic [DATA_W-1:0]       memRdData,
  input  logic [DATA_W-1:0]       aluResult,
  input  seqCtl_t                 ctl,
  output logic [CMD_W-1:0]        cmdByte,
  output logic [PC_W-1:0]         pc,
  output logic [DATA_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memWrData,
  output logic [1:0]              cacheLoad,
  output logic [DATA_W-1:0]       cacheData
);

  localparam int HALF = DATA_W / 2;
  localparam logic [PC_W-1:0] PC_ONE  = PC_W'(1);
  localparam logic [PC_W-1:0] PC_LEAP = PC_W'(SKIP_COUNT + 1);

  logic [DATA_W-1:0] argReg;
  logic [CMD_W-1:0]  cmdReg;
  logic [DATA_W-1:0] opReg;
  logic [PC_W-1:0]   pcQ;
  logic [PC_W-1:0]   jumpTarget;

  assign cmdByte   = cmdReg;
  assign pc        = pcQ;
  assign memWrData = opReg;

  // instruction register: argument above command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      argReg <= '0;
      cmdReg <= '0;
    end else if (ctl.irLoad) begin
      argReg <= instrWord[DATA_W+CMD_W-1:CMD_W];
      cmdReg <= instrWord[CMD_W-1:0];
    end
  end

  // operand holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg <= '0;
    end else if (ctl.opLatch) begin
      case (ctl.opSrc)
        SRC_MEM: opReg <= memRdData;
        SRC_ALU: opReg <= aluResult;
        default: opReg <= argReg;
      endcase
    end
  end

  always_comb begin
    case (ctl.addrSel)
      ADDR_HI:  memAddr = DATA_W'(argReg[DATA_W-1:HALF]);
      ADDR_LO:  memAddr = DATA_W'(argReg[HALF-1:0]);
      ADDR_OPF: memAddr = DATA_W'(cmdReg[2:0]);
      default:  memAddr = argReg;
    endcase
  end

  always_comb begin
    case (ctl.cacheSrc)
      SRC_MEM: cacheData = memRdData;
      SRC_ALU: cacheData = aluResult;
      default: cacheData = argReg;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : gCache
      assign cacheLoad[g] = ctl.cacheLd && (ctl.cacheSel == g[0]);
    end
  endgenerate

  assign jumpTarget = ctl.jumpFromMem ? PC_W'(memRdData) : PC_W'(argReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else begin
      case (ctl.pcAct)
        PC_INCR: pcQ <= pcQ + PC_ONE;
        PC_SKIP: pcQ <= pcQ + PC_LEAP;
        PC_JUMP: pcQ <= jumpTarget;
        default: pcQ <= pcQ;
      endcase
    end
  end

endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PC_W       = 8,
  parameter int SKIP_COUNT = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W+CMD_W-1:0] instrWord,
  input  logic [DATA_W-1:0]       memRdData,
  input  logic [DATA_W-1:0]       aluResult,
  input  logic                    skipTaken,
  output logic [PC_W-1:0]         pc,
  output logic [STEP_W-1:0]       step,
  output logic                    fetch,
  output logic [DATA_W-1:0]       memAddr,
  output logic                    memRdEn,
  output logic                    memWrEn,
  output logic [DATA_W-1:0]       memWrData,
  output logic [1:0]              cacheLoad,
  output logic [DATA_W-1:0]       cacheData,
  output logic [2:0]              opSel,
  output logic                    unsignedCmp,
  output logic                    cmpEval,
  output logic                    pcIncr,
  output logic                    pcSkip,
  output logic                    pcJump
);

  seqCtl_t          ctl;
  logic [CMD_W-1:0] cmdByte;

  seq_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .cmdByte   (cmdByte),
    .skipTaken (skipTaken),
    .step      (step),
    .ctl       (ctl)
  );

  seq_datapath #(
    .DATA_W     (DATA_W),
    .PC_W       (PC_W),
    .SKIP_COUNT (SKIP_COUNT)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .memRdData (memRdData),
    .aluResult (aluResult),
    .ctl       (ctl),
    .cmdByte   (cmdByte),
    .pc        (pc),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .cacheLoad (cacheLoad),
    .cacheData (cacheData)
  );

  assign fetch       = ctl.irLoad;
  assign memRdEn     = ctl.memRd;
  assign memWrEn     = ctl.memWr;
  assign cmpEval     = ctl.cmpEval;
  assign opSel       = cmdByte[2:0];
  assign unsignedCmp = cmdByte[ALT_BIT];
  assign pcIncr      = (ctl.pcAct == PC_INCR);
  assign pcSkip      = (ctl.pcAct == PC_SKIP);
  assign pcJump      = (ctl.pcAct == PC_JUMP);

endmodule

// File: rtl/instr_sequencer_checker.sv
module instr_sequencer_checker
  import seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PC_W       = 8,
  parameter int SKIP_COUNT = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [PC_W-1:0]         pc,
  input logic [STEP_W-1:0]       step,
  input logic                    fetch,
  input logic                    memRdEn,
  input logic                    memWrEn,
  input logic [1:0]              cacheLoad,
  input logic                    cmpEval,
  input logic                    pcIncr,
  input logic                    pcSkip,
  input logic                    pcJump
);

  logic anyUpd;
  assign anyUpd = pcIncr | pcSkip | pcJump;

  p_single_update_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pcIncr, pcSkip, pcJump}));

  p_step_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    !anyUpd |=> step == $past(step) + ST_1);

  p_step_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    anyUpd |=> step == ST_0 && fetch);

  p_no_update_on_fetch_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetch |-> !anyUpd && !memRdEn && !memWrEn && cacheLoad == 2'b00);

  p_step_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    step <= ST_6);

  p_pc_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !anyUpd |=> $stable(pc));

  p_pc_incr_r12: assert property (@(posedge clk) disable iff (!rstN)
    pcIncr |=> pc == $past(pc) + PC_W'(1));

  p_skip_leap_r9: assert property (@(posedge clk) disable iff (!rstN)
    pcSkip |=> pc == $past(pc) + PC_W'(SKIP_COUNT + 1));

  p_skip_third_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    pcSkip |-> step == ST_2);

  p_cmp_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmpEval |-> step == ST_1);

  p_mem_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  p_cache_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cacheLoad));

endmodule

bind instr_sequencer instr_sequencer_checker #(
  .DATA_W     (DATA_W),
  .PC_W       (PC_W),
  .SKIP_COUNT (SKIP_COUNT)
) chk (.*);

// File: tb/instr_sequencer_test.sv
module instr_sequencer_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instrWord;
  logic [7:0]  memRdData = '0;
  logic [7:0]  aluResult;
  logic        skipTaken = 1'b0;
  logic [7:0]  pc;
  logic [2:0]  step;
  logic        fetch;
  logic [7:0]  memAddr;
  logic        memRdEn, memWrEn;
  logic [7:0]  memWrData;
  logic [1:0]  cacheLoad;
  logic [7:0]  cacheData;
  logic [2:0]  opSel;
  logic        unsignedCmp, cmpEval, pcIncr, pcSkip, pcJump;

  logic [15:0] progMem [256];
  logic [7:0]  dataMem [256];
  logic [7:0]  cache0 = '0, cache1 = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  instr_sequencer uut (.*);

  assign instrWord = progMem[pc];

  // memory stub: synchronous read, one-tick latency
  always @(posedge clk) begin
    if (memWrEn) dataMem[memAddr] <= memWrData;
    if (memRdEn) memRdData <= dataMem[memAddr];
    if (cacheLoad[0]) cache0 <= cacheData;
    if (cacheLoad[1]) cache1 <= cacheData;
  end

  // ALU stub
  always_comb begin
    case (opSel)
      3'd0: aluResult = cache0 + cache1;
      3'd1: aluResult = cache0 - cache1;
      3'd2: aluResult = cache0 * cache1;
      3'd3: aluResult = (cache1 == 0) ? 8'hFF : cache0 / cache1;
      3'd4: aluResult = cache0 & cache1;
      3'd5: aluResult = cache0 | cache1;
      3'd6: aluResult = cache0 ^ cache1;
      default: aluResult = ~cache0;
    endcase
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // observations of one instruction
  int obsTicks, startPc, endPc, updCnt, updAt, stepErr;
  int rdStep, rdAddr, wrStep, wrAddr, wrData;
  int ldStep, ldMask, ldData, cmpStep, cmpUns, cmpOp;

  // call at a falling edge with step 0
  task automatic runInstr(input logic [15:0] word);
    int n;
    startPc = pc;
    progMem[pc] = word;
    updCnt = 0; updAt = -1; stepErr = 0;
    rdStep = -1; rdAddr = -1; wrStep = -1; wrAddr = -1; wrData = -1;
    ldStep = -1; ldMask = 0; ldData = -1; cmpStep = -1; cmpUns = -1; cmpOp = -1;
    n = 0;
    do begin
      if (int'(step) != n || fetch != (step == 0)) stepErr++;
      if (memRdEn) begin rdStep = step; rdAddr = memAddr; end
      if (memWrEn) begin wrStep = step; wrAddr = memAddr; wrData = memWrData; end
      if (cacheLoad != 0) begin ldStep = step; ldMask = cacheLoad; ldData = cacheData; end
      if (cmpEval) begin cmpStep = step; cmpUns = unsignedCmp; cmpOp = opSel; end
      if (pcIncr | pcSkip | pcJump) begin updCnt++; updAt = n; end
      @(negedge clk);
      n++;
    end while (step != 0 && n < 20);
    obsTicks = n;
    endPc = pc;
  endtask

  task automatic testReset();
    chk("R2 pc in reset", pc, 0);
    chk("R2 step in reset", step, 0);
  endtask

  task automatic testImov();
    runInstr(16'hAB9D);
    chk("R8 imov ticks", obsTicks, 6);
    chk("R8 imov write step", wrStep, 4);
    chk("R8 imov write addr", wrAddr, 5);
    chk("R8 imov write data", wrData, 8'hAB);
    chk("R12 imov pc", endPc, (startPc + 1) % 256);
    chk("R3 imov step sequence", stepErr, 0);
    chk("R3 imov update at last tick", updAt, obsTicks - 1);
  endtask

  task automatic testLoads();
    runInstr(16'h0508);
    chk("R4 load ticks", obsTicks, 4);
    chk("R4 load read step", rdStep, 2);
    chk("R1 load address from high byte", rdAddr, 5);
    chk("R4 load cache step", ldStep, 3);
    chk("R4 load cache select", ldMask, 1);
    chk("R4 load data", ldData, 8'hAB);
    runInstr(16'h3489);
    chk("R4 iload ticks", obsTicks, 3);
    chk("R4 iload cache step", ldStep, 2);
    chk("R4 iload cache select", ldMask, 2);
    chk("R1 iload data from high byte", ldData, 8'h34);
  endtask

  task automatic testAluMem();
    runInstr(16'h0210);
    chk("R5 add ticks", obsTicks, 4);
    chk("R5 add write step", wrStep, 3);
    chk("R5 add write addr", wrAddr, 2);
    chk("R5 add data", wrData, 8'hDF);
    runInstr(16'h0311);
    chk("R5 sub data", wrData, 8'h77);
    chk("R1 sub opSel", opSel, 1);
    runInstr(16'h0416);
    chk("R5 xor data", wrData, 8'h9F);
  endtask

  task automatic testMove();
    runInstr(16'h2318);
    chk("R7 mov ticks", obsTicks, 7);
    chk("R7 mov read step", rdStep, 2);
    chk("R7 mov read addr", rdAddr, 2);
    chk("R7 mov write step", wrStep, 5);
    chk("R7 mov write addr", wrAddr, 3);
    chk("R7 mov write data", wrData, 8'hDF);
    chk("R3 mov step sequence", stepErr, 0);
    runInstr(16'h0309);
    chk("R7 mov result read back", ldData, 8'hDF);
  endtask

  task automatic testAluCache();
    runInstr(16'h0095);
    chk("R6 orc ticks", obsTicks, 3);
    chk("R6 orc step", ldStep, 2);
    chk("R6 orc cache0 only", ldMask, 1);
    chk("R6 orc data", ldData, 8'hFF);
    runInstr(16'h0588);
    runInstr(16'h0389);
    runInstr(16'h0092);
    chk("R6 mulc data", ldData, 8'h0F);
    runInstr(16'h0097);
    chk("R6 invc data", ldData, 8'hF0);
  endtask

  task automatic runSkip(input logic [15:0] word, input logic take, input int expTicks,
                         input int expUns, input string tag);
    skipTaken = take;
    runInstr(word);
    skipTaken = 1'b0;
    chk({tag, " ticks"}, obsTicks, expTicks);
    chk({tag, " pc"}, endPc, (startPc + ((expTicks == 3) ? 3 : 1)) % 256);
    chk({tag, " compare step"}, cmpStep, 1);
    chk({tag, " unsigned flag"}, cmpUns, expUns);
    chk({tag, " single update"}, updCnt, 1);
  endtask

  task automatic testSkips();
    runSkip(16'h0022, 1'b0, 2, 0, "R9 eq not taken");
    runSkip(16'h0022, 1'b1, 3, 0, "R9 eq taken");
    runSkip(16'h00A3, 1'b1, 3, 1, "R9 uge taken");
    chk("R1 uge opSel", cmpOp, 3);
    runSkip(16'h0020, 1'b1, 2, 0, "R9 never");
    runSkip(16'h0027, 1'b0, 3, 0, "R9 always");
    runSkip(16'h00A0, 1'b1, 2, 1, "R9 unsigned never");
  endtask

  task automatic testJumps();
    runInstr(16'h40A8);
    chk("R10 ijmp ticks", obsTicks, 4);
    chk("R10 ijmp target", endPc, 8'h40);
    runInstr(16'h7E9E);
    runInstr(16'h0628);
    chk("R10 jmp ticks", obsTicks, 4);
    chk("R10 jmp read step", rdStep, 2);
    chk("R10 jmp read addr", rdAddr, 6);
    chk("R10 jmp target", endPc, 8'h7E);
  endtask

  task automatic testUndefined();
    logic [15:0] words [8];
    words = '{16'h0000, 16'h0030, 16'h000A, 16'h0019,
              16'h0029, 16'h0080, 16'h00F8, 16'h00B5};
    for (int i = 0; i < 8; i++) begin
      runInstr(words[i]);
      chk($sformatf("R11 idle 0x%04h ticks", words[i]), obsTicks, 2);
      chk($sformatf("R11 idle 0x%04h pc", words[i]), endPc, (startPc + 1) % 256);
      chk($sformatf("R11 idle 0x%04h no strobes", words[i]),
          int'(rdStep != -1) + int'(wrStep != -1) + int'(ldStep != -1), 0);
    end
  endtask

  task automatic testWrap();
    runInstr(16'hFFA8);
    chk("R12 jump to last address", endPc, 8'hFF);
    runInstr(16'h0000);
    chk("R12 pc wraps", endPc, 0);
    chk("R12 single update", updCnt, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      progMem[i] = '0;
    end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testImov();
    testLoads();
    testAluMem();
    testMove();
    testAluCache();
    testSkips();
    testJumps();
    testUndefined();
    testWrap();
    summary();
    $finish;
  end

endmodule